// File: doc/BRIEF.md
# Multi-line vectored interrupt arbiter

This block gathers interrupt requests from a group of serial lines and turns them into two master request outputs, one for the receive side and one for the transmit side. Each line owns three request bits: a received-character request and a dataset-change request on the receive side, and a transmit request. Per-line set and clear strobes, plus a per-line reset, maintain these bits.

When the interrupt controller acknowledges the receive or the transmit master request, the block answers in the same cycle with the vector of the lowest-numbered line that has a pending request of that kind. On the following clock it retires the acknowledged request or requests. Vectors are spaced eight apart per line above a programmable base, and the transmit vector of a line sits four above its receive vector. A run-time line count limits which lines take part in requests and acknowledges.

Top module: `vec_irq_arbiter`

## Requirements
- R1: A set strobe for a source on an active line records that request. From the next clock onward it shows on the matching master request.
- R2: `rx_irq` is high exactly when some active line holds a received-character or a dataset-change request. After reset no request is held.
- R3: `tx_irq` is high exactly when some active line holds a transmit request.
- R4: While `rx_ack` is high and a receive-side request is pending, `rx_vec` equals `vec_base + 8*L`, where L is the lowest active line holding either receive-side request. On the next clock both receive-side requests of line L are cleared, and no other line's requests change.
- R5: While `tx_ack` is high and a transmit request is pending, `tx_vec` equals `vec_base + 8*L + 4`, where L is the lowest active line with a transmit request. On the next clock only that line's transmit request is cleared.
- R6: A vector output is 0 when its acknowledge is low, and also when its acknowledge finds no pending request of its kind.
- R7: A line reset strobe clears all three requests of that line on the next clock.
- R8: A clear strobe removes only the request of its own source on its own line.
- R9: A set strobe takes priority over any clear in the same cycle, whether that clear comes from a clear strobe, a line reset or an acknowledge.
- R10: A line whose index is at or above `active_lines` ignores set strobes and holds no request. It never contributes to a master request or to an acknowledge, and it still has no request after the count is raised again.
- R11: Vector arithmetic wraps modulo 2^VEC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| active_lines | input | CNT_W | Number of lines taking part (0 to NUM_LINES) |
| rx_set | input | NUM_LINES | Per-line received-character request set |
| rx_clr | input | NUM_LINES | Per-line received-character request clear |
| ds_set | input | NUM_LINES | Per-line dataset-change request set |
| ds_clr | input | NUM_LINES | Per-line dataset-change request clear |
| tx_set | input | NUM_LINES | Per-line transmit request set |
| tx_clr | input | NUM_LINES | Per-line transmit request clear |
| line_rst | input | NUM_LINES | Per-line reset of all three requests |
| rx_ack | input | 1 | Receive-side acknowledge strobe |
| tx_ack | input | 1 | Transmit acknowledge strobe |
| vec_base | input | VEC_W | Vector base |
| rx_irq | output | 1 | Receive-side master request |
| tx_irq | output | 1 | Transmit master request |
| rx_vec | output | VEC_W | Receive vector, valid while rx_ack is high |
| tx_vec | output | VEC_W | Transmit vector, valid while tx_ack is high |

## Verification
The hardest case to reach from the ports is a collision: a set, a clear, a line reset and an acknowledge all land on the same line bit in one cycle. A second hard case is lowering the line count while requests are still held above it. Directed phases stack these strobes deliberately on one line. A long random phase then applies sparse, overlapping strobes while it also moves the line count and the vector base. A behavioural model in the bench, kept as plain per-line flags, predicts both master requests and both vectors on every cycle. The base is driven near the top of its range so that the vector wraps.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
   // Each line occupies 2**LINE_SHIFT vector slots.
   localparam int LINE_SHIFT = 3;
   // Transmit vector sits this far above the line's receive vector.
   localparam int TX_OFS     = 4;
   // Largest supported line count.
   localparam int MAX_LINES  = 64;
endpackage

// File: rtl/vec_irq_bank.sv
// One request bit per line. Priority order: inactive line, then set, then clear.
module vec_irq_bank #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   input  logic [N-1:0] keep_i,
   output logic [N-1:0] q_o
);
   for (genvar g = 0; g < N; g++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          bit_q <= 1'b0;
         else if (!keep_i[g]) bit_q <= 1'b0;
         else if (set_i[g])   bit_q <= 1'b1;
         else if (clr_i[g])   bit_q <= 1'b0;
      end
      assign q_o[g] = bit_q;
   end
endmodule

// File: rtl/vec_irq_pick.sv
// Lowest-index finder over a request vector.
module vec_irq_pick #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   assign any_o = |req_i;

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter
   import vec_irq_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int VEC_W     = 9,
   parameter int CNT_W     = $clog2(NUM_LINES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CNT_W-1:0]     active_lines,
   input  logic [NUM_LINES-1:0] rx_set,
   input  logic [NUM_LINES-1:0] rx_clr,
   input  logic [NUM_LINES-1:0] ds_set,
   input  logic [NUM_LINES-1:0] ds_clr,
   input  logic [NUM_LINES-1:0] tx_set,
   input  logic [NUM_LINES-1:0] tx_clr,
   input  logic [NUM_LINES-1:0] line_rst,
   input  logic                 rx_ack,
   input  logic                 tx_ack,
   input  logic [VEC_W-1:0]     vec_base,
   output logic                 rx_irq,
   output logic                 tx_irq,
   output logic [VEC_W-1:0]     rx_vec,
   output logic [VEC_W-1:0]     tx_vec
);
   localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

   if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
      $error("vec_irq_arbiter: NUM_LINES out of range");
   end
   if (VEC_W < IDX_W + LINE_SHIFT) begin : g_bad_vec
      $error("vec_irq_arbiter: VEC_W too narrow for line spacing");
   end
   if (CNT_W < $clog2(NUM_LINES + 1)) begin : g_bad_cnt
      $error("vec_irq_arbiter: CNT_W cannot hold the line count");
   end

   logic [NUM_LINES-1:0] act;
   for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_act
      assign act[gi] = (32'(active_lines) > gi);
   end

   logic [NUM_LINES-1:0] rx_q, ds_q, tx_q;
   logic [NUM_LINES-1:0] rx_pend, tx_pend;
   logic [NUM_LINES-1:0] rx_hit, tx_hit;
   logic                 rx_any, tx_any;
   logic [IDX_W-1:0]     rx_idx, tx_idx;

   // Mask in the same cycle so that lowering the count hides held bits at once.
   assign rx_pend = (rx_q | ds_q) & act;
   assign tx_pend = tx_q & act;

   vec_irq_pick #(.N(NUM_LINES), .IDX_W(IDX_W)) u_rx_pick (
      .req_i (rx_pend),
      .any_o (rx_any),
      .idx_o (rx_idx)
   );

   vec_irq_pick #(.N(NUM_LINES), .IDX_W(IDX_W)) u_tx_pick (
      .req_i (tx_pend),
      .any_o (tx_any),
      .idx_o (tx_idx)
   );

   assign rx_irq = rx_any;
   assign tx_irq = tx_any;

   // One-hot retire masks for the acknowledged line.
   assign rx_hit = (rx_ack && rx_any) ? (NUM_LINES'(1) << rx_idx) : '0;
   assign tx_hit = (tx_ack && tx_any) ? (NUM_LINES'(1) << tx_idx) : '0;

   assign rx_vec = (rx_ack && rx_any)
                 ? VEC_W'(vec_base + (VEC_W'(rx_idx) << LINE_SHIFT))
                 : '0;
   assign tx_vec = (tx_ack && tx_any)
                 ? VEC_W'(vec_base + (VEC_W'(tx_idx) << LINE_SHIFT) + VEC_W'(TX_OFS))
                 : '0;

   vec_irq_bank #(.N(NUM_LINES)) u_rx_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (rx_set),
      .clr_i  (rx_clr | line_rst | rx_hit),
      .keep_i (act),
      .q_o    (rx_q)
   );

   vec_irq_bank #(.N(NUM_LINES)) u_ds_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (ds_set),
      .clr_i  (ds_clr | line_rst | rx_hit),
      .keep_i (act),
      .q_o    (ds_q)
   );

   vec_irq_bank #(.N(NUM_LINES)) u_tx_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (tx_set),
      .clr_i  (tx_clr | line_rst | tx_hit),
      .keep_i (act),
      .q_o    (tx_q)
   );
endmodule

// File: rtl/vec_irq_arbiter_chk.sv
module vec_irq_arbiter_chk #(
   parameter int NUM_LINES = 16,
   parameter int VEC_W     = 9,
   parameter int CNT_W     = $clog2(NUM_LINES + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [CNT_W-1:0]     active_lines,
   input logic [NUM_LINES-1:0] rx_set,
   input logic [NUM_LINES-1:0] ds_set,
   input logic [NUM_LINES-1:0] tx_set,
   input logic                 rx_ack,
   input logic                 tx_ack,
   input logic [VEC_W-1:0]     vec_base,
   input logic                 rx_irq,
   input logic                 tx_irq,
   input logic [VEC_W-1:0]     rx_vec,
   input logic [VEC_W-1:0]     tx_vec
);
   logic [NUM_LINES-1:0] act;
   logic [VEC_W-1:0]     rx_off, tx_off;
   logic                 live;

   always_comb begin
      for (int i = 0; i < NUM_LINES; i++) act[i] = (32'(active_lines) > i);
   end

   assign rx_off = VEC_W'(rx_vec - vec_base);
   assign tx_off = VEC_W'(tx_vec - vec_base);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   assert_rx_set_seen_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(|((rx_set | ds_set) & act)) && active_lines >= $past(active_lines))
      |-> rx_irq);

   assert_tx_set_seen_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(|(tx_set & act)) && active_lines >= $past(active_lines))
      |-> tx_irq);

   assert_rx_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ack && rx_irq) |-> (rx_off[2:0] == 3'd0));

   assert_tx_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ack && tx_irq) |-> (tx_off[2:0] == 3'd4));

   assert_rx_idle_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_ack || !rx_irq) |-> (rx_vec == '0));

   assert_tx_idle_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_ack || !tx_irq) |-> (tx_vec == '0));

   assert_no_lines_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (active_lines == '0) |-> (!rx_irq && !tx_irq));
endmodule

bind vec_irq_arbiter vec_irq_arbiter_chk #(
   .NUM_LINES (NUM_LINES),
   .VEC_W     (VEC_W),
   .CNT_W     (CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .active_lines (active_lines),
   .rx_set       (rx_set),
   .ds_set       (ds_set),
   .tx_set       (tx_set),
   .rx_ack       (rx_ack),
   .tx_ack       (tx_ack),
   .vec_base     (vec_base),
   .rx_irq       (rx_irq),
   .tx_irq       (tx_irq),
   .rx_vec       (rx_vec),
   .tx_vec       (tx_vec)
);

// File: tb/tb_vec_irq_arbiter.sv
module tb_vec_irq_arbiter;
   localparam int N  = 16;
   localparam int VW = 9;
   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [CW-1:0] active_lines;
   logic [N-1:0]  rx_set, rx_clr, ds_set, ds_clr, tx_set, tx_clr, line_rst;
   logic          rx_ack, tx_ack;
   logic [VW-1:0] vec_base;
   logic          rx_irq, tx_irq;
   logic [VW-1:0] rx_vec, tx_vec;

   always #4 clk = ~clk;

   vec_irq_arbiter #(.NUM_LINES(N), .VEC_W(VW)) dut (
      .clk(clk), .rst_n(rst_n), .active_lines(active_lines),
      .rx_set(rx_set), .rx_clr(rx_clr), .ds_set(ds_set), .ds_clr(ds_clr),
      .tx_set(tx_set), .tx_clr(tx_clr), .line_rst(line_rst),
      .rx_ack(rx_ack), .tx_ack(tx_ack), .vec_base(vec_base),
      .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_vec(rx_vec), .tx_vec(tx_vec)
   );

   int    total = 0;
   int    bad   = 0;
   bit    m_rx[N];
   bit    m_ds[N];
   bit    m_tx[N];
   string phase = "reset";

   task automatic check(string req, logic [VW-1:0] act_v, logic [VW-1:0] exp_v);
      total++;
      if (act_v !== exp_v) begin
         bad++;
         $display("FAIL %s phase=%s actual=%0h expected=%0h", req, phase, act_v, exp_v);
      end
   endtask

   task automatic idle();
      rx_set = '0; rx_clr = '0; ds_set = '0; ds_clr = '0;
      tx_set = '0; tx_clr = '0; line_rst = '0; rx_ack = 1'b0; tx_ack = 1'b0;
   endtask

   // Called just after a negedge with inputs applied: compare, clock, update model.
   task automatic cyc();
      int rl = -1;
      int tl = -1;
      int al;
      logic [VW-1:0] erv, etv;
      #1;
      al = int'(active_lines);
      for (int i = 0; i < N; i++) begin
         if (i < al) begin
            if (rl < 0 && (m_rx[i] || m_ds[i])) rl = i;
            if (tl < 0 && m_tx[i]) tl = i;
         end
      end
      erv = (rx_ack && rl >= 0) ? VW'(int'(vec_base) + 8 * rl) : '0;
      etv = (tx_ack && tl >= 0) ? VW'(int'(vec_base) + 8 * tl + 4) : '0;
      check("R2", VW'(rx_irq), VW'(rl >= 0));
      check("R3", VW'(tx_irq), VW'(tl >= 0));
      check("R4", rx_vec, erv);
      check("R5", tx_vec, etv);
      @(posedge clk);
      if (rst_n) begin
         for (int i = 0; i < N; i++) begin
            if (i >= al) begin
               m_rx[i] = 1'b0; m_ds[i] = 1'b0; m_tx[i] = 1'b0;
            end else begin
               if (rx_set[i]) m_rx[i] = 1'b1;
               else if (rx_clr[i] || line_rst[i] || (rx_ack && rl == i)) m_rx[i] = 1'b0;
               if (ds_set[i]) m_ds[i] = 1'b1;
               else if (ds_clr[i] || line_rst[i] || (rx_ack && rl == i)) m_ds[i] = 1'b0;
               if (tx_set[i]) m_tx[i] = 1'b1;
               else if (tx_clr[i] || line_rst[i] || (tx_ack && tl == i)) m_tx[i] = 1'b0;
            end
         end
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_rx[i] = 0; m_ds[i] = 0; m_tx[i] = 0; end
      idle();
      rst_n = 1'b0;
      active_lines = CW'(N);
      vec_base = 9'h040;
      @(negedge clk);
      phase = "R2 reset";
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();

      // R1: a single receive set shows on the master request.
      phase = "R1";
      rx_set[3] = 1'b1; cyc(); idle(); cyc();

      // R4: lowest line wins, both receive sources retired together.
      phase = "R4";
      ds_set[1] = 1'b1; rx_set[1] = 1'b1; tx_set[5] = 1'b1; tx_set[2] = 1'b1; cyc(); idle();
      rx_ack = 1'b1; cyc(); cyc();
      phase = "R6";
      cyc(); idle(); cyc();

      // R5: transmit order 2 then 5, then empty.
      phase = "R5";
      tx_ack = 1'b1; cyc(); cyc();
      phase = "R6";
      cyc(); idle(); cyc();

      // R8: clearing one source leaves the other.
      phase = "R8";
      rx_set[7] = 1'b1; ds_set[7] = 1'b1; cyc(); idle();
      rx_clr[7] = 1'b1; cyc(); idle(); cyc();
      rx_ack = 1'b1; cyc(); idle(); cyc();

      // R7: line reset clears all three.
      phase = "R7";
      rx_set[4] = 1'b1; ds_set[4] = 1'b1; tx_set[4] = 1'b1; cyc(); idle();
      line_rst[4] = 1'b1; cyc(); idle(); cyc();

      // R9: set beats clear, line reset and acknowledge.
      phase = "R9";
      rx_set[6] = 1'b1; rx_clr[6] = 1'b1; line_rst[6] = 1'b1; cyc(); idle(); cyc();
      tx_set[0] = 1'b1; cyc(); tx_ack = 1'b1; cyc(); idle(); cyc();
      line_rst = '1; cyc(); idle(); cyc();

      // R10: lines above the count are inert.
      phase = "R10";
      active_lines = 5'd4;
      rx_set[10] = 1'b1; tx_set[12] = 1'b1; cyc(); idle(); cyc();
      rx_ack = 1'b1; tx_ack = 1'b1; cyc(); idle();
      rx_set[2] = 1'b1; cyc(); idle();
      active_lines = 5'd2; cyc(); cyc();
      active_lines = 5'd4; cyc(); cyc();
      active_lines = 5'd0; tx_set = '1; cyc(); idle(); cyc();

      // R11: vector wraps at the top of its range.
      phase = "R11";
      active_lines = CW'(N);
      vec_base = 9'h1F8;
      rx_set[2] = 1'b1; tx_set[3] = 1'b1; cyc(); idle();
      rx_ack = 1'b1; tx_ack = 1'b1; cyc(); idle(); cyc();

      // Random mix of all strobes, counts and bases.
      phase = "R1 random";
      for (int c = 0; c < 4000; c++) begin
         rx_set   = N'($urandom & $urandom & $urandom & $urandom);
         ds_set   = N'($urandom & $urandom & $urandom & $urandom);
         tx_set   = N'($urandom & $urandom & $urandom & $urandom);
         rx_clr   = N'($urandom & $urandom & $urandom & $urandom);
         ds_clr   = N'($urandom & $urandom & $urandom & $urandom);
         tx_clr   = N'($urandom & $urandom & $urandom & $urandom);
         line_rst = N'($urandom & $urandom & $urandom & $urandom & $urandom);
         rx_ack   = ($urandom_range(0, 2) == 0);
         tx_ack   = ($urandom_range(0, 2) == 0);
         if ($urandom_range(0, 99) == 0) active_lines = CW'($urandom_range(0, N));
         if ($urandom_range(0, 199) == 0) vec_base = VW'($urandom);
         cyc();
      end
      idle(); cyc();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule